// File: doc/BRIEF.md
# External Bus Zone Controller

This block turns single CPU bus requests into timed accesses on an external memory bus. The top bits of the CPU address select one of five external zones, here called zone 0, 1, 2, 6 and 7. Each zone has its own wait-state count. Each zone also has its own choice of whether to stall on an external ready line. Zones 0, 1 and 2 each drive their own active-low chip select. Zones 6 and 7 share a fourth chip select, which goes low when either of them is accessed.

A boot-mode pin is sampled while reset is held and stored in a mode bit, which software can later overwrite. With the mode bit set, the high vector region belongs to zone 7 and goes out on the external bus. With the mode bit clear, zone 7 is switched off. A hit on the vector region then gives a one-cycle internal boot-ROM select instead, with no external cycle.

Every external access runs the same sequence: one lead cycle with the chip select low, an active phase with the read or write strobe low, and one trail cycle. A one-cycle completion pulse follows the trail cycle.

Top module: `ext_zone_ctrl`

## Requirements
- R1: While reset is held and on the cycle after it, every chip select and both strobes are high, and `cpu_done` and `boot_sel` are low. Reset sets every zone to a wait count of all ones with ready ignored, and loads `mode_bit` from `mode_pin`.
- R2: The region code is `cpu_addr[ADDR_W-1 -: 4]`. Code 0x0 selects zone 0 on `zcs_n[0]`, code 0x1 selects zone 1 on `zcs_n[1]`, and code 0x8 selects zone 2 on `zcs_n[2]`. Code 0xA selects zone 6 and code 0xF (with `mode_bit`=1) selects zone 7, and both drive the shared `zcs_n[3]`. At most one chip select is low at any time.
- R3: After a request is accepted at edge 0, the chip select is low from edge 0 up to edge E, where E = wait+2 without stalls. The strobe is low from edge 1 up to edge E, and `cpu_done` is high for exactly the one cycle after edge E+1.
- R4: For a zone that honours ready, the active phase ends only at an edge where the twice-synchronised ready is high. If ready rises just after edge R, then E = max(wait+2, R+3).
- R5: For a zone that ignores ready, E = wait+2 whatever level ready has.
- R6: For a read, `cpu_rdata` holds the value `ext_rdata` had at edge E, which is the end of the last active cycle. Changes to `ext_rdata` after that edge are not seen.
- R7: For a write, `ext_wr_n` is the strobe and `ext_rd_n` stays high; for a read, the reverse. `ext_addr` and `ext_wdata` carry the request's address and data from edge 0.
- R8: With `mode_bit`=0, a request to region 0xF gives `boot_sel` high for the one cycle after the accept edge, drives no chip select and gives no `cpu_done`.
- R9: `mode_we` loads `mode_wdata` into `mode_bit` at the next edge. The mode bit changes only how region 0xF is handled; zone 6 behaves the same in both modes.
- R10: A request to any region code that belongs to no zone and is not 0xF drives no chip select, no `cpu_done` and no `boot_sel`.
- R11: A request made while an access is in progress is dropped. It starts no second access and gives no extra `cpu_done`.
- R12: A configuration write with `cfg_slot` = 0..4 sets the wait count and the ready choice of zone 0, 1, 2, 6 or 7 respectively. A write with `cfg_slot` of 5 or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin | input | 1 | Boot-mode level, captured while reset is held |
| mode_we | input | 1 | Software write strobe for the mode bit |
| mode_wdata | input | 1 | New mode bit value |
| mode_bit | output | 1 | Current mode bit |
| cfg_we | input | 1 | Zone configuration write strobe |
| cfg_slot | input | 3 | Zone slot index written (0..4) |
| cfg_wait | input | WAIT_W | Wait-state count for the slot |
| cfg_use_rdy | input | 1 | 1 = slot stalls on ready |
| cpu_req | input | 1 | Access request, one cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Captured read data |
| cpu_done | output | 1 | One-cycle completion pulse |
| boot_sel | output | 1 | One-cycle internal boot-ROM select |
| zcs_n | output | 4 | Chip selects, active low; bit 3 is shared by zones 6 and 7 |
| ext_addr | output | ADDR_W | External address |
| ext_wdata | output | DATA_W | External write data |
| ext_rdata | input | DATA_W | External read data |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_ready | input | 1 | Asynchronous ready from the external device |

## Verification
The bench counts clock edges from the edge that accepts a request. It expects the chip select one edge after acceptance (edge 0) and the strobe one edge after that. The completion pulse is due at edge wait+3. When a ready-honouring zone is stalled, the pulse is due at edge max(wait+2, R+3)+1, where R is the edge after which the bench raised ready. The boot-ROM select is due one edge after acceptance, and a mode write takes effect one edge after its strobe. Every output is sampled 1 ns after an edge, so each observation sees that edge's register updates and none of the next edge's.

// File: rtl/zone_pkg.sv
`timescale 1ns/1ps
package zone_pkg;
  localparam int NUM_ZONES  = 5;
  localparam int NUM_CS     = 4;
  localparam int SLOT_W     = 3;
  localparam int REGION_W   = 4;
  localparam int BOOT_SLOT  = 4;
  localparam int SHARED_LO  = 3;
  // region code per slot, slot 0 in the low nibble
  localparam logic [NUM_ZONES*REGION_W-1:0] REGION_CODES = {4'hF, 4'hA, 4'h8, 4'h1, 4'h0};

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_ACTIVE, ST_TRAIL} acc_state_t;

  function automatic int cs_of_slot(input logic [SLOT_W-1:0] s);
    return (int'(s) >= SHARED_LO) ? NUM_CS - 1 : int'(s);
  endfunction
endpackage

// File: rtl/zone_decode.sv
`timescale 1ns/1ps
module zone_decode
  import zone_pkg::*;
(
  input  logic [REGION_W-1:0] region,
  input  logic                mode,
  output logic                zone_hit,
  output logic [SLOT_W-1:0]   slot,
  output logic                boot_hit
);
  logic [NUM_ZONES-1:0] match;

  for (genvar i = 0; i < NUM_ZONES; i++) begin : g_match
    if (i == BOOT_SLOT) begin : g_boot
      assign match[i] = (region == REGION_CODES[i*REGION_W +: REGION_W]) && mode;
    end else begin : g_plain
      assign match[i] = (region == REGION_CODES[i*REGION_W +: REGION_W]);
    end
  end

  always_comb begin
    zone_hit = |match;
    slot     = '0;
    for (int i = 0; i < NUM_ZONES; i++) begin
      if (match[i]) slot = SLOT_W'(i);
    end
    boot_hit = (region == REGION_CODES[BOOT_SLOT*REGION_W +: REGION_W]) && !mode;
  end
endmodule

// File: rtl/zone_cfg.sv
`timescale 1ns/1ps
module zone_cfg
  import zone_pkg::*;
#(
  parameter int WAIT_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [SLOT_W-1:0]           wr_slot,
  input  logic [WAIT_W-1:0]           wr_wait,
  input  logic                        wr_use_rdy,
  output logic [NUM_ZONES*WAIT_W-1:0] waits,
  output logic [NUM_ZONES-1:0]        use_rdy
);
  for (genvar i = 0; i < NUM_ZONES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        waits[i*WAIT_W +: WAIT_W] <= '1;
        use_rdy[i]                <= 1'b0;
      end else if (wr_en && (wr_slot == SLOT_W'(i))) begin
        waits[i*WAIT_W +: WAIT_W] <= wr_wait;
        use_rdy[i]                <= wr_use_rdy;
      end
    end
  end
endmodule

// File: rtl/rdy_sync.sv
`timescale 1ns/1ps
module rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/acc_fsm.sv
`timescale 1ns/1ps
module acc_fsm
  import zone_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic [WAIT_W-1:0] start_wait,
  input  logic              start_use_rdy,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              rdy_s,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              busy,
  output logic [NUM_CS-1:0] cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  acc_state_t        st, st_nx;
  logic [WAIT_W-1:0] cnt;
  logic [SLOT_W-1:0] slot_q, slot_nx;
  logic              use_q, we_q, leave_active;
  logic [NUM_CS-1:0] cs_nx;

  always_comb begin
    leave_active = (cnt == '0) && (!use_q || rdy_s);
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (start) st_nx = ST_LEAD;
      ST_LEAD:   st_nx = ST_ACTIVE;
      ST_ACTIVE: if (leave_active) st_nx = ST_TRAIL;
      ST_TRAIL:  st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
    slot_nx = (st == ST_IDLE) ? start_slot : slot_q;
    for (int c = 0; c < NUM_CS; c++) begin
      cs_nx[c] = (st_nx != ST_IDLE) && (cs_of_slot(slot_nx) == c);
    end
  end

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      slot_q    <= '0;
      use_q     <= 1'b0;
      we_q      <= 1'b0;
      cs_n      <= '1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      ext_addr  <= '0;
      ext_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      st   <= st_nx;
      done <= (st == ST_TRAIL);
      cs_n <= ~cs_nx;
      rd_n <= !((st_nx == ST_ACTIVE) && !we_q);
      wr_n <= !((st_nx == ST_ACTIVE) && we_q);
      if (st == ST_IDLE && start) begin
        cnt       <= start_wait;
        slot_q    <= start_slot;
        use_q     <= start_use_rdy;
        we_q      <= start_we;
        ext_addr  <= start_addr;
        ext_wdata <= start_wdata;
      end else if (st == ST_ACTIVE && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (st == ST_ACTIVE && leave_active && !we_q) rdata <= ext_rdata;
    end
  end
endmodule

// File: rtl/ext_zone_ctrl.sv
`timescale 1ns/1ps
module ext_zone_ctrl
  import zone_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int WAIT_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_pin,
  input  logic              mode_we,
  input  logic              mode_wdata,
  output logic              mode_bit,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_slot,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_use_rdy,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              boot_sel,
  output logic [3:0]        zcs_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  input  logic              ext_ready
);
  logic                        mode_q, boot_q, busy, start;
  logic                        zone_hit, boot_hit, rdy_s;
  logic [SLOT_W-1:0]           slot;
  logic [NUM_ZONES*WAIT_W-1:0] waits;
  logic [NUM_ZONES-1:0]        use_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_pin;
      boot_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      boot_q <= cpu_req && boot_hit && !busy;
    end
  end

  assign mode_bit = mode_q;
  assign boot_sel = boot_q;
  assign start    = cpu_req && zone_hit && !busy;

  zone_decode i_dec (
    .region   (cpu_addr[ADDR_W-1 -: REGION_W]),
    .mode     (mode_q),
    .zone_hit (zone_hit),
    .slot     (slot),
    .boot_hit (boot_hit)
  );

  zone_cfg #(.WAIT_W(WAIT_W)) i_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_we),
    .wr_slot    (cfg_slot),
    .wr_wait    (cfg_wait),
    .wr_use_rdy (cfg_use_rdy),
    .waits      (waits),
    .use_rdy    (use_rdy)
  );

  rdy_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_ready),
    .dout (rdy_s)
  );

  acc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) i_fsm (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .start_slot    (slot),
    .start_wait    (waits[slot*WAIT_W +: WAIT_W]),
    .start_use_rdy (use_rdy[slot]),
    .start_we      (cpu_we),
    .start_addr    (cpu_addr),
    .start_wdata   (cpu_wdata),
    .rdy_s         (rdy_s),
    .ext_rdata     (ext_rdata),
    .busy          (busy),
    .cs_n          (zcs_n),
    .rd_n          (ext_rd_n),
    .wr_n          (ext_wr_n),
    .ext_addr      (ext_addr),
    .ext_wdata     (ext_wdata),
    .done          (cpu_done),
    .rdata         (cpu_rdata)
  );
endmodule

// File: rtl/zone_ctrl_chk.sv
`timescale 1ns/1ps
module zone_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_pin,
  input logic       mode_bit,
  input logic [3:0] zcs_n,
  input logic       ext_rd_n,
  input logic       ext_wr_n,
  input logic       cpu_done,
  input logic       boot_sel
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (&zcs_n && ext_rd_n && ext_wr_n && !cpu_done && !boot_sel));

  a_r1_mode_capture: assert property (@(posedge clk)
    rst |=> (mode_bit == $past(mode_pin)));

  a_r2_single_cs: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~zcs_n));

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  a_r3_done_after_cs: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> (&zcs_n && !$past(&zcs_n)));

  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> !(&zcs_n));

  a_r3_lead_no_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(&zcs_n) |-> (ext_rd_n && ext_wr_n));

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));

  a_r8_boot_no_cs: assert property (@(posedge clk) disable iff (rst)
    boot_sel |-> &zcs_n);
endmodule

bind ext_zone_ctrl zone_ctrl_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_pin (mode_pin),
  .mode_bit (mode_bit),
  .zcs_n    (zcs_n),
  .ext_rd_n (ext_rd_n),
  .ext_wr_n (ext_wr_n),
  .cpu_done (cpu_done),
  .boot_sel (boot_sel)
);

// File: tb/test_ext_zone_ctrl.sv
`timescale 1ns/1ps
module test_ext_zone_ctrl;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int WW = 5;

  logic          clk = 1'b0;
  logic          rst, mode_pin, mode_we, mode_wdata, mode_bit;
  logic          cfg_we, cfg_use_rdy;
  logic [2:0]    cfg_slot;
  logic [WW-1:0] cfg_wait;
  logic          cpu_req, cpu_we, cpu_done, boot_sel;
  logic [AW-1:0] cpu_addr, ext_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, ext_wdata, ext_rdata;
  logic [3:0]    zcs_n;
  logic          ext_rd_n, ext_wr_n, ext_ready;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  int sh_wait [5];
  bit sh_use  [5];

  always #2.5 clk = ~clk;

  ext_zone_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) i_ext_zone_ctrl (
    .clk(clk), .rst(rst), .mode_pin(mode_pin), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .mode_bit(mode_bit), .cfg_we(cfg_we),
    .cfg_slot(cfg_slot), .cfg_wait(cfg_wait), .cfg_use_rdy(cfg_use_rdy),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .boot_sel(boot_sel), .zcs_n(zcs_n), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_ready(ext_ready)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [3:0] region_of(input int slot);
    case (slot)
      0: return 4'h0;
      1: return 4'h1;
      2: return 4'h8;
      3: return 4'hA;
      default: return 4'hF;
    endcase
  endfunction

  function automatic int cs_index(input int slot);
    return (slot < 3) ? slot : 3;
  endfunction

  task automatic set_cfg(input int slot, input int w, input bit u);
    cfg_we = 1; cfg_slot = 3'(slot); cfg_wait = WW'(w); cfg_use_rdy = u;
    @(posedge clk); #1;
    cfg_we = 0;
    if (slot < 5) begin sh_wait[slot] = w; sh_use[slot] = u; end
  endtask

  // rdy_at < 0: ready stays high; otherwise ready is low before the request
  // and is raised just after edge rdy_at (edge 0 = accept edge)
  task automatic do_acc(input int slot, input bit we, input int rdy_at,
                        input bit poke, input string rq);
    logic [AW-1:0] a;
    logic [DW-1:0] wd, rv;
    logic [3:0]    exp_cs;
    int w, ex, lat, k, got, bad;
    bit u, strobe, other;
    w  = sh_wait[slot];
    u  = sh_use[slot];
    ex = w + 2;
    if (u && rdy_at >= 0 && rdy_at + 3 > ex) ex = rdy_at + 3;
    lat = ex + 1;
    a  = {region_of(slot), 16'($urandom)};
    wd = 16'($urandom);
    rv = 16'($urandom);
    if (rdy_at >= 0) begin
      ext_ready = 0;
      repeat (4) @(posedge clk);
      #1;
    end
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; ext_rdata = rv;
    @(posedge clk); #1;
    cpu_req = 0;
    k = 0; got = -1; bad = 0;
    while (k <= lat + 2) begin
      exp_cs = (k <= ex) ? ~(4'b1 << cs_index(slot)) : 4'hF;
      if (k == 0) check(zcs_n == exp_cs, "R2", "chip select", 32'(zcs_n), 32'(exp_cs));
      if (k == 1) begin
        check(ext_addr == a, "R7", "address", 32'(ext_addr), 32'(a));
        if (we) check(ext_wdata == wd, "R7", "write data", 32'(ext_wdata), 32'(wd));
      end
      strobe = we ? ext_wr_n : ext_rd_n;
      other  = we ? ext_rd_n : ext_wr_n;
      if (zcs_n != exp_cs) bad++;
      if (strobe != !(k >= 1 && k < ex)) bad++;
      if (other != 1'b1) bad++;
      if (cpu_done != (k == lat)) bad++;
      if (cpu_done && got < 0) got = k;
      if (k == rdy_at) ext_ready = 1;
      if (k == ex) ext_rdata = ~rv;
      if (poke && k == 2) begin cpu_req = 1; cpu_addr = {4'h0, 16'h0}; end
      if (poke && k == 3) cpu_req = 0;
      @(posedge clk); #1;
      k++;
    end
    ext_ready = 1;
    check(got == lat, rq, "done latency", 32'(got), 32'(lat));
    check(bad == 0, poke ? "R11" : "R3", "cycle shape mismatches", 32'(bad), 0);
    if (!we) check(cpu_rdata == rv, "R6", "read data", 32'(cpu_rdata), 32'(rv));
  endtask

  task automatic do_none(input logic [3:0] reg_code, input bit exp_boot, input string rq);
    int bad;
    bad = 0;
    cpu_req = 1; cpu_we = 0; cpu_addr = {reg_code, 16'($urandom)};
    @(posedge clk); #1;
    cpu_req = 0;
    for (int k = 0; k < 8; k++) begin
      if (zcs_n != 4'hF || cpu_done) bad++;
      if (boot_sel != (exp_boot && k == 0)) bad++;
      @(posedge clk); #1;
    end
    check(bad == 0, rq, "no-access cycle mismatches", 32'(bad), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; mode_pin = 1; mode_we = 0; mode_wdata = 0;
    cfg_we = 0; cfg_slot = 0; cfg_wait = 0; cfg_use_rdy = 0;
    cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    ext_rdata = 0; ext_ready = 1;
    for (int i = 0; i < 5; i++) begin sh_wait[i] = 31; sh_use[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(zcs_n == 4'hF, "R1", "chip selects in reset", 32'(zcs_n), 32'hF);
    check(ext_rd_n && ext_wr_n, "R1", "strobes in reset", 32'({ext_rd_n, ext_wr_n}), 3);
    check(!cpu_done && !boot_sel, "R1", "done/boot in reset", 32'({cpu_done, boot_sel}), 0);
    check(mode_bit == 1'b1, "R1", "mode captured", 32'(mode_bit), 1);
    rst = 0;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset default: wait all ones, ready ignored, even with ready low
    do_acc(0, 0, 50, 0, "R1");

    // directed configs
    set_cfg(0, 0, 0);
    set_cfg(1, 3, 0);
    set_cfg(2, 7, 1);
    set_cfg(3, 2, 1);
    set_cfg(4, 1, 0);
    do_acc(0, 0, -1, 0, "R3");          // minimum wait
    do_acc(1, 1, -1, 0, "R3");
    do_acc(4, 0, -1, 0, "R2");          // zone 7 on shared select
    do_acc(3, 1, -1, 0, "R2");          // zone 6 on shared select
    do_acc(2, 0, 15, 0, "R4");          // long stall
    do_acc(2, 0, 0, 0, "R4");           // ready back before count ends
    set_cfg(0, 0, 1);
    do_acc(0, 0, 0, 0, "R4");           // wait 0, one stall cycle
    do_acc(1, 0, 60, 0, "R5");          // ready low throughout, ignored
    do_acc(1, 1, -1, 1, "R3");          // poke while busy
    do_none(4'h5, 0, "R10");
    do_none(4'hC, 0, "R10");

    // R12: slot index 5 and 7 are no zone
    set_cfg(5, 0, 1);
    set_cfg(7, 0, 1);
    do_acc(2, 0, -1, 0, "R12");
    do_acc(4, 1, -1, 0, "R12");

    // R9 / R8: software clears mode bit
    mode_we = 1; mode_wdata = 0;
    @(posedge clk); #1;
    mode_we = 0;
    check(mode_bit == 1'b0, "R9", "mode write", 32'(mode_bit), 0);
    do_none(4'hF, 1, "R8");
    do_acc(3, 0, -1, 0, "R9");          // zone 6 unaffected
    mode_we = 1; mode_wdata = 1;
    @(posedge clk); #1;
    mode_we = 0;
    check(mode_bit == 1'b1, "R9", "mode write back", 32'(mode_bit), 1);
    do_acc(4, 0, -1, 0, "R9");

    // random phase
    for (int it = 0; it < 40; it++) begin
      int s, r;
      s = $urandom_range(0, 4);
      set_cfg(s, $urandom_range(0, 9), 1'($urandom_range(0, 1)));
      r = ($urandom_range(0, 3) == 0) ? -1 : $urandom_range(0, 12);
      do_acc(s, 1'($urandom_range(0, 1)), r, 0, sh_use[s] ? "R4" : "R5");
    end

    // R1: reset with the pin low
    rst = 1; mode_pin = 0;
    repeat (2) @(posedge clk);
    #1;
    check(mode_bit == 1'b0, "R1", "mode captured low", 32'(mode_bit), 0);
    rst = 0;
    repeat (4) @(posedge clk);
    #1;
    do_none(4'hF, 1, "R8");
    finish_run();
  end
endmodule